// File: doc/BRIEF.md
# Multi-mode operand address generator

This block turns one instruction operand into either a plain value or an effective memory address. A request carries a 4-bit mode code, two register indices, a 32-bit literal/displacement and a 2-bit scale code. The block reads its own 32-entry, 32-bit register file and produces a one-cycle `res_valid` pulse with the result. A flag marks whether the result is an address or a plain value.

Nine of the mode codes finish one cycle after acceptance. The memory-indirect mode first reads a pointer from data memory and takes one extra cycle, with `req_ready` low during the wait. The post-increment and pre-decrement modes write the changed base register back in the cycle of acceptance. A separate load port lets the surrounding logic fill the register file.

Top module: `opnd_agen`

## Requirements
- R1: After synchronous reset `res_valid` is 0, `req_ready` is 1 and every register reads as zero.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. Mode 0 (register value) returns R[ri] and mode 1 (literal) returns `req_imm`, both with `res_is_addr`=0. The result comes with a single-cycle `res_valid` pulse in the cycle after acceptance.
- R3: Mode 2 (absolute) returns `req_imm`, mode 3 (register pointer) returns R[ri] and mode 4 (base plus offset) returns R[ri]+imm. All three set `res_is_addr`=1 and complete one cycle after acceptance.
- R4: Mode 5 (base plus index) returns R[ri]+R[rj]. Mode 6 (scaled) returns R[ri] + R[rj]*2^scale + imm, where scale codes 0,1,2,3 mean factors 1,2,4,8. Both set `res_is_addr`=1.
- R5: Mode 7 (post-increment) returns the old R[ri] as an address and leaves R[ri]+4 in the register. A request accepted in the next cycle sees the updated value.
- R6: Mode 8 (pre-decrement) returns R[ri]-4 as an address and leaves that same value in R[ri].
- R7: Mode 9 (pointer fetch) drives `mem_rd_en`=1 with `mem_rd_addr`=R[ri] in the cycle of acceptance. Memory returns data one cycle later. `req_ready` is 0 and `res_valid` is 0 in that following cycle, and `res_valid`=1 with the fetched word and `res_is_addr`=1 comes two cycles after acceptance. `mem_rd_en` is 0 at all other times.
- R8: Register 0 always reads as zero. Post-modify writebacks and loads to register 0 are ignored.
- R9: Mode codes 10 to 15 are accepted and return value 0 with `res_is_addr`=0 one cycle later.
- R10: All address arithmetic wraps modulo 2^32.
- R11: When a post-modify writeback and a load through the load port target the same register in the same cycle, the writeback wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operand request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_mode | input | 4 | Addressing mode code |
| req_ri | input | 5 | Base / source register index |
| req_rj | input | 5 | Index register index |
| req_imm | input | 32 | Literal or displacement |
| req_scale | input | 2 | Index scale code (factor 2^code) |
| res_valid | output | 1 | Result pulse |
| res_value | output | 32 | Operand value or effective address |
| res_is_addr | output | 1 | 1 when `res_value` is an address |
| mem_rd_en | output | 1 | Pointer read request to data memory |
| mem_rd_addr | output | 32 | Pointer read address |
| mem_rd_data | input | 32 | Pointer read data, one cycle after `mem_rd_en` |
| ld_en | input | 1 | Register file load strobe |
| ld_idx | input | 5 | Register file load index |
| ld_data | input | 32 | Register file load data |

## Verification
A corrupted register shows up at the ports on the first request that reads that register. The bench therefore follows every post-modify operation and every load with a register-value request, so that a lost or misdirected writeback appears within two cycles. A wrong pointer-fetch state would show as a missing or early `res_valid`, or as `req_ready` staying low past the single wait cycle. The checker catches that on the next edge, and the bench checks the port values at each of the two cycles.

// File: rtl/agen_pkg.sv
package agen_pkg;

    localparam int AG_XLEN = 32;
    localparam int AG_NREG = 32;
    localparam int AG_STEP = 4;
    localparam int AG_MODEW = 4;

    typedef enum logic [AG_MODEW-1:0] {
        AM_REG      = 4'd0,
        AM_LIT      = 4'd1,
        AM_ABS      = 4'd2,
        AM_REGPTR   = 4'd3,
        AM_BASEOFF  = 4'd4,
        AM_BASEIDX  = 4'd5,
        AM_SCALED   = 4'd6,
        AM_POSTINC  = 4'd7,
        AM_PREDEC   = 4'd8,
        AM_PTRFETCH = 4'd9
    } agen_mode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } agen_state_e;

    typedef struct packed {
        logic [AG_XLEN-1:0] value;
        logic               is_addr;
        logic               wb_en;
        logic [AG_XLEN-1:0] wb_val;
        logic               is_fetch;
    } agen_calc_t;

    function automatic logic [AG_XLEN-1:0] scale_index(
        input logic [AG_XLEN-1:0] idx,
        input logic [1:0]         code
    );
        return idx << code;
    endfunction

endpackage

// File: rtl/agen_regfile.sv
module agen_regfile
    import agen_pkg::*;
#(
    parameter int NREG = AG_NREG,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IDXW-1:0]    ra_idx,
    input  logic [IDXW-1:0]    rb_idx,
    output logic [AG_XLEN-1:0] ra_data,
    output logic [AG_XLEN-1:0] rb_data,
    input  logic               wb_en,
    input  logic [IDXW-1:0]    wb_idx,
    input  logic [AG_XLEN-1:0] wb_data,
    input  logic               ld_en,
    input  logic [IDXW-1:0]    ld_idx,
    input  logic [AG_XLEN-1:0] ld_data
);

    logic [AG_XLEN-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g == 0) begin : g_zero
            always_ff @(posedge clk) begin
                regs[g] <= '0;
            end
        end else begin : g_live
            logic wb_hit;
            logic ld_hit;
            assign wb_hit = wb_en && (wb_idx == IDXW'(g));
            assign ld_hit = ld_en && (ld_idx == IDXW'(g));
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs[g] <= '0;
                end else if (wb_hit) begin
                    regs[g] <= wb_data;
                end else if (ld_hit) begin
                    regs[g] <= ld_data;
                end
            end
        end
    end

    always_comb begin
        ra_data = (ra_idx == '0) ? '0 : regs[ra_idx];
        rb_data = (rb_idx == '0) ? '0 : regs[rb_idx];
    end

endmodule

// File: rtl/agen_calc.sv
module agen_calc
    import agen_pkg::*;
#(
    parameter int STEP = AG_STEP
) (
    input  agen_mode_e         mode,
    input  logic [AG_XLEN-1:0] ri_val,
    input  logic [AG_XLEN-1:0] rj_val,
    input  logic [AG_XLEN-1:0] imm,
    input  logic [1:0]         scale,
    output agen_calc_t         res
);

    localparam logic [AG_XLEN-1:0] STEP_V = AG_XLEN'(STEP);

    logic [AG_XLEN-1:0] scaled_idx;
    logic [AG_XLEN-1:0] dec_val;

    assign scaled_idx = scale_index(rj_val, scale);
    assign dec_val    = ri_val - STEP_V;

    always_comb begin
        res = '0;
        unique case (mode)
            AM_REG: begin
                res.value = ri_val;
            end
            AM_LIT: begin
                res.value = imm;
            end
            AM_ABS: begin
                res.value   = imm;
                res.is_addr = 1'b1;
            end
            AM_REGPTR: begin
                res.value   = ri_val;
                res.is_addr = 1'b1;
            end
            AM_BASEOFF: begin
                res.value   = ri_val + imm;
                res.is_addr = 1'b1;
            end
            AM_BASEIDX: begin
                res.value   = ri_val + rj_val;
                res.is_addr = 1'b1;
            end
            AM_SCALED: begin
                res.value   = ri_val + scaled_idx + imm;
                res.is_addr = 1'b1;
            end
            AM_POSTINC: begin
                res.value   = ri_val;
                res.is_addr = 1'b1;
                res.wb_en   = 1'b1;
                res.wb_val  = ri_val + STEP_V;
            end
            AM_PREDEC: begin
                res.value   = dec_val;
                res.is_addr = 1'b1;
                res.wb_en   = 1'b1;
                res.wb_val  = dec_val;
            end
            AM_PTRFETCH: begin
                res.value    = ri_val;
                res.is_addr  = 1'b1;
                res.is_fetch = 1'b1;
            end
            default: begin
                res = '0;
            end
        endcase
    end

endmodule

// File: rtl/agen_ctrl.sv
module agen_ctrl
    import agen_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  agen_calc_t         calc,
    input  logic [AG_XLEN-1:0] mem_rd_data,
    output logic               req_ready,
    output logic               accept,
    output logic               mem_rd_en,
    output logic [AG_XLEN-1:0] mem_rd_addr,
    output logic               res_valid,
    output logic [AG_XLEN-1:0] res_value,
    output logic               res_is_addr
);

    agen_state_e state_q;

    assign req_ready   = (state_q == ST_IDLE);
    assign accept      = req_valid && req_ready;
    assign mem_rd_en   = accept && calc.is_fetch;
    assign mem_rd_addr = calc.value;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            res_valid   <= 1'b0;
            res_value   <= '0;
            res_is_addr <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (calc.is_fetch) begin
                            state_q <= ST_FETCH;
                        end else begin
                            res_valid   <= 1'b1;
                            res_value   <= calc.value;
                            res_is_addr <= calc.is_addr;
                        end
                    end
                end
                ST_FETCH: begin
                    res_valid   <= 1'b1;
                    res_value   <= mem_rd_data;
                    res_is_addr <= 1'b1;
                    state_q     <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/opnd_agen.sv
module opnd_agen
    import agen_pkg::*;
#(
    parameter int NREG = AG_NREG,
    parameter int STEP = AG_STEP,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [AG_MODEW-1:0] req_mode,
    input  logic [IDXW-1:0]    req_ri,
    input  logic [IDXW-1:0]    req_rj,
    input  logic [AG_XLEN-1:0] req_imm,
    input  logic [1:0]         req_scale,
    output logic               res_valid,
    output logic [AG_XLEN-1:0] res_value,
    output logic               res_is_addr,
    output logic               mem_rd_en,
    output logic [AG_XLEN-1:0] mem_rd_addr,
    input  logic [AG_XLEN-1:0] mem_rd_data,
    input  logic               ld_en,
    input  logic [IDXW-1:0]    ld_idx,
    input  logic [AG_XLEN-1:0] ld_data
);

    logic [AG_XLEN-1:0] ri_val;
    logic [AG_XLEN-1:0] rj_val;
    agen_calc_t         calc;
    logic               accept;
    logic               wb_fire;

    assign wb_fire = accept && calc.wb_en;

    agen_regfile #(.NREG(NREG)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .ra_idx  (req_ri),
        .rb_idx  (req_rj),
        .ra_data (ri_val),
        .rb_data (rj_val),
        .wb_en   (wb_fire),
        .wb_idx  (req_ri),
        .wb_data (calc.wb_val),
        .ld_en   (ld_en),
        .ld_idx  (ld_idx),
        .ld_data (ld_data)
    );

    agen_calc #(.STEP(STEP)) u_calc (
        .mode   (agen_mode_e'(req_mode)),
        .ri_val (ri_val),
        .rj_val (rj_val),
        .imm    (req_imm),
        .scale  (req_scale),
        .res    (calc)
    );

    agen_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .calc        (calc),
        .mem_rd_data (mem_rd_data),
        .req_ready   (req_ready),
        .accept      (accept),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .res_valid   (res_valid),
        .res_value   (res_value),
        .res_is_addr (res_is_addr)
    );

endmodule

// File: rtl/agen_chk.sv
module agen_chk
    import agen_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic [AG_MODEW-1:0] req_mode,
    input logic               res_valid,
    input logic [AG_XLEN-1:0] res_value,
    input logic               res_is_addr,
    input logic               mem_rd_en
);

    logic acc;
    assign acc = req_valid && req_ready;

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!res_valid && req_ready)); // R1

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (acc && req_mode != AM_PTRFETCH) |=> (res_valid && req_ready)); // R2

    AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (rst)
        (!acc && req_ready) |=> !res_valid); // R2

    AST_FETCH_WAIT: assert property (@(posedge clk) disable iff (rst)
        (acc && req_mode == AM_PTRFETCH) |=> (!req_ready && !res_valid)); // R7

    AST_FETCH_DONE: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> (res_valid && res_is_addr && req_ready)); // R7

    AST_FETCH_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> (acc && req_mode == AM_PTRFETCH)); // R7

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc && req_mode >= 4'd10) |=> (res_valid && !res_is_addr && res_value == '0)); // R9

endmodule

bind opnd_agen agen_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_mode    (req_mode),
    .res_valid   (res_valid),
    .res_value   (res_value),
    .res_is_addr (res_is_addr),
    .mem_rd_en   (mem_rd_en)
);

// File: tb/opnd_agen_tb.sv
`timescale 1ns/1ps
module opnd_agen_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_mode = '0;
    logic [4:0]  req_ri = '0;
    logic [4:0]  req_rj = '0;
    logic [31:0] req_imm = '0;
    logic [1:0]  req_scale = '0;
    logic        res_valid;
    logic [31:0] res_value;
    logic        res_is_addr;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;
    logic        ld_en = 1'b0;
    logic [4:0]  ld_idx = '0;
    logic [31:0] ld_data = '0;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    opnd_agen u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_mode(req_mode), .req_ri(req_ri), .req_rj(req_rj), .req_imm(req_imm),
        .req_scale(req_scale), .res_valid(res_valid), .res_value(res_value),
        .res_is_addr(res_is_addr), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return a * 32'd3 + 32'h0000_1000;
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem_word(mem_rd_addr);
    end

    typedef struct packed {
        logic [3:0]  mode;
        logic [4:0]  ri;
        logic [4:0]  rj;
        logic [31:0] imm;
        logic [1:0]  sc;
        logic [31:0] exp;
        logic        adr;
        logic [7:0]  rq;
    } vec_t;

    // registers preloaded: r1=0x100 r2=0x10 r3=0xFFFFFFF0 r4=7
    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 5'd1, 5'd0, 32'h0,        2'd0, 32'h0000_0100, 1'b0, 8'd2},  // R2 register
        '{4'd1, 5'd0, 5'd0, 32'hDEAD_BEEF, 2'd0, 32'hDEAD_BEEF, 1'b0, 8'd2}, // R2 literal
        '{4'd2, 5'd0, 5'd0, 32'h40,       2'd0, 32'h0000_0040, 1'b1, 8'd3},  // R3 absolute
        '{4'd3, 5'd2, 5'd0, 32'h0,        2'd0, 32'h0000_0010, 1'b1, 8'd3},  // R3 pointer
        '{4'd4, 5'd1, 5'd0, 32'h24,       2'd0, 32'h0000_0124, 1'b1, 8'd3},  // R3 base+offset
        '{4'd4, 5'd3, 5'd0, 32'h20,       2'd0, 32'h0000_0010, 1'b1, 8'd10}, // R10 wrap
        '{4'd5, 5'd1, 5'd2, 32'h0,        2'd0, 32'h0000_0110, 1'b1, 8'd4},  // R4 base+index
        '{4'd6, 5'd1, 5'd4, 32'h8,        2'd0, 32'h0000_010F, 1'b1, 8'd4},  // R4 x1
        '{4'd6, 5'd1, 5'd4, 32'h8,        2'd1, 32'h0000_0116, 1'b1, 8'd4},  // R4 x2
        '{4'd6, 5'd1, 5'd4, 32'h8,        2'd2, 32'h0000_0124, 1'b1, 8'd4},  // R4 x4
        '{4'd6, 5'd1, 5'd4, 32'h8,        2'd3, 32'h0000_0140, 1'b1, 8'd4},  // R4 x8
        '{4'd0, 5'd0, 5'd0, 32'h0,        2'd0, 32'h0000_0000, 1'b0, 8'd8},  // R8 r0
        '{4'd12, 5'd1, 5'd2, 32'h55,      2'd1, 32'h0000_0000, 1'b0, 8'd9}   // R9 reserved
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [4:0] idx, input logic [31:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = idx; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // drives one request for one cycle; returns at the negedge after acceptance
    task automatic issue(input logic [3:0] m, input logic [4:0] ri, input logic [4:0] rj,
                         input logic [31:0] imm, input logic [1:0] sc);
        @(negedge clk);
        req_mode = m; req_ri = ri; req_rj = rj; req_imm = imm; req_scale = sc;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic read_reg(input logic [4:0] idx, input string tag, input logic [31:0] exp);
        issue(4'd0, idx, 5'd0, 32'h0, 2'd0);
        chk(tag, {31'b0, res_valid}, 32'd1);
        chk(tag, res_value, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 res_valid", {31'b0, res_valid}, 32'd0);
        chk("R1 req_ready", {31'b0, req_ready}, 32'd1);
        read_reg(5'd1, "R1 r1 cleared", 32'h0);

        load(5'd1, 32'h0000_0100);
        load(5'd2, 32'h0000_0010);
        load(5'd3, 32'hFFFF_FFF0);
        load(5'd4, 32'h0000_0007);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[i].rq, i);
            issue(VECS[i].mode, VECS[i].ri, VECS[i].rj, VECS[i].imm, VECS[i].sc);
            chk({tag, " valid"}, {31'b0, res_valid}, 32'd1);
            chk({tag, " value"}, res_value, VECS[i].exp);
            chk({tag, " is_addr"}, {31'b0, res_is_addr}, {31'b0, VECS[i].adr});
        end

        // R2 pulse is one cycle long
        @(negedge clk);
        chk("R2 pulse ends", {31'b0, res_valid}, 32'd0);

        // R5 post-increment
        load(5'd5, 32'h0000_2000);
        issue(4'd7, 5'd5, 5'd0, 32'h0, 2'd0);
        chk("R5 addr", res_value, 32'h0000_2000);
        chk("R5 is_addr", {31'b0, res_is_addr}, 32'd1);
        read_reg(5'd5, "R5 reg updated", 32'h0000_2004);

        // R6 pre-decrement
        issue(4'd8, 5'd5, 5'd0, 32'h0, 2'd0);
        chk("R6 addr", res_value, 32'h0000_2000);
        read_reg(5'd5, "R6 reg updated", 32'h0000_2000);

        // R5 back-to-back post-increment
        load(5'd6, 32'h0000_0300);
        @(negedge clk);
        req_mode = 4'd7; req_ri = 5'd6; req_valid = 1'b1;
        @(negedge clk);
        chk("R5 b2b first", res_value, 32'h0000_0300);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R5 b2b second", res_value, 32'h0000_0304);
        read_reg(5'd6, "R5 b2b reg", 32'h0000_0308);

        // R8 register 0 protection
        issue(4'd8, 5'd0, 5'd0, 32'h0, 2'd0);
        chk("R8 predec r0 addr", res_value, 32'hFFFF_FFFC);
        read_reg(5'd0, "R8 r0 after predec", 32'h0);
        issue(4'd7, 5'd0, 5'd0, 32'h0, 2'd0);
        chk("R8 postinc r0 addr", res_value, 32'h0);
        load(5'd0, 32'h0000_0005);
        read_reg(5'd0, "R8 r0 after load", 32'h0);

        // R10 wrap on pre-decrement of zero-valued register
        load(5'd7, 32'h0000_0002);
        issue(4'd8, 5'd7, 5'd0, 32'h0, 2'd0);
        chk("R10 predec wrap", res_value, 32'hFFFF_FFFE);

        // R11 writeback beats load on same register
        @(negedge clk);
        req_mode = 4'd7; req_ri = 5'd5; req_valid = 1'b1;
        ld_en = 1'b1; ld_idx = 5'd5; ld_data = 32'h0000_9999;
        @(negedge clk);
        req_valid = 1'b0; ld_en = 1'b0;
        read_reg(5'd5, "R11 writeback wins", 32'h0000_2004);

        // R7 pointer fetch
        @(negedge clk);
        req_mode = 4'd9; req_ri = 5'd1; req_valid = 1'b1;
        #1;
        chk("R7 rd_en", {31'b0, mem_rd_en}, 32'd1);
        chk("R7 rd_addr", mem_rd_addr, 32'h0000_0100);
        @(negedge clk);
        req_mode = 4'd0; req_ri = 5'd2;   // held valid: must wait
        chk("R7 wait ready", {31'b0, req_ready}, 32'd0);
        chk("R7 wait valid", {31'b0, res_valid}, 32'd0);
        chk("R7 no second read", {31'b0, mem_rd_en}, 32'd0);
        @(negedge clk);
        chk("R7 done valid", {31'b0, res_valid}, 32'd1);
        chk("R7 fetched value", res_value, mem_word(32'h0000_0100));
        chk("R7 is_addr", {31'b0, res_is_addr}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7 held request served", res_value, 32'h0000_0010);

        // R1 reset again clears registers
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 res_valid after reset", {31'b0, res_valid}, 32'd0);
        read_reg(5'd1, "R1 r1 after reset", 32'h0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule